// File: doc/BRIEF.md
# 8b/10b Code-Group Decoder with Error Flags

This block sits on the receive side of a serial link, after the word aligner. Each clock it takes one framed 10-bit code group and returns the 8-bit value it stands for, a flag that marks control characters, and three error flags. The disparity error flag marks a running-disparity violation. The code error flag marks a pattern that is not a legal code group. The third flag is the OR of the other two. The byte and every flag pass through the same two-stage pipeline, so each result lines up with the word it describes.

The decoder needs no preset starting polarity. Reset clears its running-disparity state. It then learns the polarity from the first accepted code group whose form is legal under only one polarity. A code group that is legal under both polarities says nothing about the polarity, so it leaves the state unlearned. Nothing is accepted until the aligner has reported that framing is complete. Once that report has been seen, it holds until the next reset.

Top module: `code_group_decoder`

## Requirements
- R1: Input bit k (0..9) carries code bit a, b, c, d, e, i, f, g, h, j in that order, with bit 0 received first. For every valid data code group, `dec_byte` bits 0..7 give the data bits A..H. Bits 4:0 are the 5-bit sub-value x and bits 7:5 the 3-bit sub-value y.
- R2: `dec_ctrl` is 1 exactly for the twelve legal control characters: K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. With `dec_ctrl` = 1, `dec_byte` holds the character value, for example 0xBC for K28.5. `dec_ctrl` is 0 for every data character and every invalid pattern.
- R3: A 10-bit pattern that is not the encoding of any legal data or control character under either running disparity sets `dec_code_err`. On that word `dec_byte` = 0 and `dec_ctrl` = 0.
- R4: Suppose the running disparity is known and a code group is legal only under the opposite polarity. Then `dec_disp_err` = 1 and the byte is still decoded. `dec_disp_err` is 0 on invalid patterns.
- R5: `dec_err` = `dec_code_err` OR `dec_disp_err` on the same word.
- R6: Reset clears the running disparity to an unknown state. The first accepted code group that is legal under only one polarity sets it, and that code group never raises `dec_disp_err`. While the state is unknown, no disparity error is flagged.
- R7: An input word is accepted only if `rx_code_vld` = 1 and `rx_aligned` is 1 in that cycle or has been 1 at some cycle since reset. Words that are not accepted produce no output and leave the disparity state unchanged.
- R8: A word accepted at clock edge n appears at the outputs, with `dec_vld` = 1, after edge n+2. The byte and all flags appear in that same cycle.
- R9: After each accepted valid code group, the running disparity takes the value left by that code group's sub-blocks, evaluated under the polarity in which the code group is legal. An invalid pattern leaves the running disparity unchanged.
- R10: When `dec_vld` = 0, `dec_byte`, `dec_ctrl`, `dec_disp_err`, `dec_code_err` and `dec_err` are all 0. Reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_code | input | 10 | Framed code group, bit 0 = first received bit a |
| rx_code_vld | input | 1 | rx_code holds a code group this cycle |
| rx_aligned | input | 1 | Word alignment has completed (level or pulse) |
| dec_byte | output | 8 | Decoded value, bit 7 = H |
| dec_ctrl | output | 1 | Decoded value is a control character |
| dec_disp_err | output | 1 | Running-disparity violation on this word |
| dec_code_err | output | 1 | Pattern is not a legal code group |
| dec_err | output | 1 | Either error on this word |
| dec_vld | output | 1 | Outputs describe an accepted word |

## Verification
A wrong running-disparity state can stay hidden while the traffic is balanced. It shows at the ports as a spurious or missing `dec_disp_err` two cycles after the first unbalanced code group that follows. The bench therefore steers the stream through learning from a balanced start, deliberate polarity flips, and invalid patterns followed by valid ones, and it compares every cycle. A wrong candidate decode or alignment gate shows at once in the byte, the control flag or `dec_vld`, on the word that follows.

// File: rtl/cgd_pkg.sv
package cgd_pkg;

  localparam int CGD_CODE_W = 10;
  localparam int CGD_BYTE_W = 8;
  localparam int CGD_X_W    = 5;
  localparam int CGD_Y_W    = 3;
  localparam int CGD_NTRY   = 4;   // {control?, positive?} candidate encodings

  function automatic int cgd_ones(input logic [CGD_CODE_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < CGD_CODE_W; i++) n += int'(v[i]);
    return n;
  endfunction

  // 6-bit patterns below are written first-bit-on-the-left (a..i)
  function automatic logic [5:0] cgd_rev6(input logic [5:0] s);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = s[5-i];
    return r;
  endfunction

  function automatic logic [3:0] cgd_rev4(input logic [3:0] s);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = s[3-i];
    return r;
  endfunction

  // data 5b->6b, negative running disparity column
  function automatic logic [5:0] cgd_tab6(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // data 3b->4b, negative column (primary form for 7)
  function automatic logic [3:0] cgd_dtab4(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  // control 3b->4b, negative column
  function automatic logic [3:0] cgd_ktab4(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b0110;
      3'd2: return 4'b1010;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b0101;
      3'd6: return 4'b1001;  default: return 4'b0111;
    endcase
  endfunction

  function automatic logic cgd_k_legal(input logic [CGD_BYTE_W-1:0] b);
    logic [4:0] x;
    x = b[4:0];
    return (x == 5'd28) ||
           (b[7:5] == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

  // full encoder: byte, control flag, running disparity (1 = positive)
  function automatic logic [CGD_CODE_W-1:0] cgd_enc10(input logic [CGD_BYTE_W-1:0] b,
                                                       input logic k, input logic rp);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] s6;
    logic [3:0] s4;
    logic       mid, alt;
    int         n6;
    x  = b[4:0];
    y  = b[7:5];
    s6 = (k && x == 5'd28) ? 6'b001111 : cgd_tab6(x);
    n6 = cgd_ones(10'(s6));
    if (rp && (n6 != 3 || (!k && x == 5'd7))) s6 = ~s6;
    n6  = cgd_ones(10'(s6));
    mid = (n6 == 3) ? rp : (n6 > 3);
    alt = !k && (y == 3'd7) &&
          ((!mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           ( mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    if (k)        s4 = cgd_ktab4(y);
    else if (alt) s4 = 4'b0111;
    else          s4 = cgd_dtab4(y);
    if (mid && (k || cgd_ones(10'(s4)) != 2 || y == 3'd3)) s4 = ~s4;
    return {cgd_rev4(s4), cgd_rev6(s6)};
  endfunction

  // running disparity left behind by a code group
  function automatic logic cgd_rd_after(input logic [CGD_CODE_W-1:0] c, input logic rp);
    int  n6, n4;
    logic mid;
    n6  = cgd_ones(10'(c[5:0]));
    n4  = cgd_ones(10'(c[9:6]));
    mid = (n6 == 3) ? rp : (n6 > 3);
    return (n4 == 2) ? mid : (n4 > 2);
  endfunction

endpackage

// File: rtl/cgd_align_gate.sv
module cgd_align_gate
  import cgd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  code_vld,
  input  logic                  aligned_in,
  input  logic [CGD_CODE_W-1:0] code_in,
  output logic                  s1_acc,
  output logic [CGD_CODE_W-1:0] s1_code
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      s1_acc  <= 1'b0;
      s1_code <= '0;
    end else begin
      seen_q  <= seen_q | aligned_in;
      s1_acc  <= code_vld & (aligned_in | seen_q);
      s1_code <= code_in;
    end
  end
endmodule

// File: rtl/cgd_classify.sv
module cgd_classify
  import cgd_pkg::*;
(
  input  logic [CGD_CODE_W-1:0] code,
  output logic [CGD_BYTE_W-1:0] cand,
  output logic                  is_k,
  output logic                  m_neg,
  output logic                  m_pos
);
  logic [5:0]          s6, t6;
  logic [3:0]          s4, t4;
  logic                k28, k28_neg;
  logic [CGD_X_W-1:0]  xc;
  logic [CGD_Y_W-1:0]  yc;
  logic                k_ok;
  logic [CGD_NTRY-1:0] hit;

  // pick a candidate value from each sub-block
  always_comb begin
    s6      = cgd_rev6(code[5:0]);
    s4      = cgd_rev4(code[9:6]);
    k28_neg = (s6 == 6'b001111);
    k28     = k28_neg || (s6 == 6'b110000);
    t6      = '0;
    t4      = '0;
    xc      = '0;
    for (int i = 0; i < 32; i++) begin
      t6 = cgd_tab6(5'(i));
      if (s6 == t6 || ((cgd_ones(10'(t6)) != 3 || i == 7) && s6 == ~t6)) xc = 5'(i);
    end
    if (k28) xc = 5'd28;
    yc = '0;
    if (k28) begin
      for (int j = 0; j < 8; j++) begin
        t4 = cgd_ktab4(3'(j));
        if ((k28_neg ? ~t4 : t4) == s4) yc = 3'(j);
      end
    end else begin
      for (int j = 0; j < 8; j++) begin
        t4 = cgd_dtab4(3'(j));
        if (s4 == t4 || ((cgd_ones(10'(t4)) != 2 || j == 3) && s4 == ~t4)) yc = 3'(j);
      end
      if (s4 == 4'b0111 || s4 == 4'b1000) yc = 3'd7;
    end
    cand = {yc, xc};
    k_ok = cgd_k_legal({yc, xc});
  end

  // confirm the candidate by re-encoding it four ways
  for (genvar g = 0; g < CGD_NTRY; g++) begin : g_try
    assign hit[g] = ((g / 2 == 0) || k_ok) &&
                    (cgd_enc10(cand, 1'(g / 2), 1'(g % 2)) == code);
  end

  assign is_k  = hit[2] | hit[3];
  assign m_neg = hit[0] | hit[2];
  assign m_pos = hit[1] | hit[3];
endmodule

// File: rtl/cgd_disparity.sv
module cgd_disparity
  import cgd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc,
  input  logic [CGD_CODE_W-1:0] code,
  input  logic                  m_neg,
  input  logic                  m_pos,
  output logic                  disp_err
);
  logic known_q, pos_q;
  logic now_ok, use_pos, upd, legal;

  always_comb begin
    legal    = m_neg | m_pos;
    now_ok   = pos_q ? m_pos : m_neg;
    disp_err = acc && known_q && legal && !now_ok;
    use_pos  = known_q ? (now_ok ? pos_q : !pos_q) : m_pos;
    upd      = acc && (known_q ? legal : (m_neg ^ m_pos));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      known_q <= 1'b0;
      pos_q   <= 1'b0;
    end else if (upd) begin
      known_q <= 1'b1;
      pos_q   <= cgd_rd_after(code, use_pos);
    end
  end
endmodule

// File: rtl/code_group_decoder.sv
module code_group_decoder
  import cgd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CGD_CODE_W-1:0] rx_code,
  input  logic                  rx_code_vld,
  input  logic                  rx_aligned,
  output logic [CGD_BYTE_W-1:0] dec_byte,
  output logic                  dec_ctrl,
  output logic                  dec_disp_err,
  output logic                  dec_code_err,
  output logic                  dec_err,
  output logic                  dec_vld
);
  logic                  s1_acc;
  logic [CGD_CODE_W-1:0] s1_code;
  logic [CGD_BYTE_W-1:0] cand;
  logic                  is_k, m_neg, m_pos, de, legal;

  cgd_align_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .code_vld   (rx_code_vld),
    .aligned_in (rx_aligned),
    .code_in    (rx_code),
    .s1_acc     (s1_acc),
    .s1_code    (s1_code)
  );

  cgd_classify u_cls (
    .code  (s1_code),
    .cand  (cand),
    .is_k  (is_k),
    .m_neg (m_neg),
    .m_pos (m_pos)
  );

  cgd_disparity u_rd (
    .clk      (clk),
    .rst      (rst),
    .acc      (s1_acc),
    .code     (s1_code),
    .m_neg    (m_neg),
    .m_pos    (m_pos),
    .disp_err (de)
  );

  assign legal = m_neg | m_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld      <= 1'b0;
      dec_byte     <= '0;
      dec_ctrl     <= 1'b0;
      dec_code_err <= 1'b0;
      dec_disp_err <= 1'b0;
      dec_err      <= 1'b0;
    end else begin
      dec_vld      <= s1_acc;
      dec_byte     <= (s1_acc && legal) ? cand : '0;
      dec_ctrl     <= s1_acc && legal && is_k;
      dec_code_err <= s1_acc && !legal;
      dec_disp_err <= de;
      dec_err      <= (s1_acc && !legal) || de;
    end
  end
endmodule

// File: rtl/code_group_decoder_chk.sv
module code_group_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_code_vld,
  input logic       rx_aligned,
  input logic [7:0] dec_byte,
  input logic       dec_ctrl,
  input logic       dec_disp_err,
  input logic       dec_code_err,
  input logic       dec_err,
  input logic       dec_vld
);
  logic seen;
  logic open_now;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else if (rx_aligned) seen <= 1'b1;
  end
  assign open_now = seen | rx_aligned;

  p_vld_latency_r8: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> $past(rx_code_vld, 2));

  p_vld_after_align_r7: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> $past(open_now, 2));

  p_bad_code_blank_r3: assert property (@(posedge clk) disable iff (rst)
    dec_code_err |-> (dec_byte == 8'h00 && !dec_ctrl && !dec_disp_err));

  p_err_merge_r5: assert property (@(posedge clk) disable iff (rst)
    dec_err == (dec_code_err | dec_disp_err));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !dec_vld |-> (dec_byte == 8'h00 && !dec_ctrl && !dec_err));

  p_ctrl_set_r2: assert property (@(posedge clk) disable iff (rst)
    dec_ctrl |-> (dec_byte[4:0] == 5'd28 ||
                  (dec_byte[7:5] == 3'd7 && (dec_byte[4:0] == 5'd23 || dec_byte[4:0] == 5'd27 ||
                                             dec_byte[4:0] == 5'd29 || dec_byte[4:0] == 5'd30))));
endmodule

bind code_group_decoder code_group_decoder_chk chk_i (.*);

// File: tb/code_group_decoder_tb.sv
`timescale 1ns/1ps
module code_group_decoder_tb_top;

  localparam time CLK_P = 4ns;

  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] rx_code;
  logic       rx_code_vld, rx_aligned;
  logic [7:0] dec_byte;
  logic       dec_ctrl, dec_disp_err, dec_code_err, dec_err, dec_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  code_group_decoder dut_i (
    .clk(clk), .rst(rst), .rx_code(rx_code), .rx_code_vld(rx_code_vld),
    .rx_aligned(rx_aligned), .dec_byte(dec_byte), .dec_ctrl(dec_ctrl),
    .dec_disp_err(dec_disp_err), .dec_code_err(dec_code_err),
    .dec_err(dec_err), .dec_vld(dec_vld)
  );

  // ---------------- bench-side encoder (stimulus and reference table) ----
  function automatic int ones(input logic [9:0] v);
    int n = 0;
    for (int i = 0; i < 10; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [5:0] five_six(input int x);
    logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
                           6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
                           6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
                           6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
                           6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
                           6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] three_four(input int y, input bit k);
    logic [3:0] d [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    logic [3:0] c [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b0101, 4'b1001, 4'b0111};
    return k ? c[y] : d[y];
  endfunction

  function automatic bit k_ok(input logic [7:0] b);
    int x = int'(b[4:0]);
    return x == 28 || (b[7:5] == 3'd7 && (x == 23 || x == 27 || x == 29 || x == 30));
  endfunction

  function automatic logic [9:0] tb_enc(input logic [7:0] b, input bit k, input bit rp);
    int x = int'(b[4:0]);
    int y = int'(b[7:5]);
    logic [5:0] s6;
    logic [3:0] s4;
    logic [9:0] r;
    bit mid;
    s6 = (k && x == 28) ? 6'b001111 : five_six(x);
    if (rp && (ones(10'(s6)) != 3 || (!k && x == 7))) s6 = ~s6;
    mid = (ones(10'(s6)) == 3) ? rp : (ones(10'(s6)) > 3);
    s4 = three_four(y, k);
    if (!k && y == 7 && ((!mid && (x == 17 || x == 18 || x == 20)) ||
                         (mid && (x == 11 || x == 13 || x == 14)))) s4 = 4'b0111;
    if (mid && (k || ones(10'(s4)) != 2 || y == 3)) s4 = ~s4;
    for (int i = 0; i < 6; i++) r[i] = s6[5-i];
    for (int i = 0; i < 4; i++) r[6+i] = s4[3-i];
    return r;
  endfunction

  function automatic bit tb_rdnext(input logic [9:0] c, input bit rp);
    int a = ones(10'(c[5:0]));
    int b = ones(10'(c[9:6]));
    bit m = (a == 3) ? rp : (a > 3);
    return (b == 2) ? m : (b > 2);
  endfunction

  logic [9:0] tbl_code [1024];
  bit         tbl_ok   [1024];
  initial begin
    for (int i = 0; i < 1024; i++) begin
      tbl_ok[i]   = !i[9] || k_ok(8'(i >> 1));
      tbl_code[i] = tb_enc(8'(i >> 1), i[9], i[0]);
    end
  end

  // ---------------- reference model ----------------
  typedef struct packed {
    logic       vld;
    logic [7:0] d;
    logic       k, ce, de, ea, al;
  } exp_t;

  exp_t  e1, e2;
  string t1, t2;
  bit    m_al, m_known, m_pos, m_prev_bad, started;

  always @(posedge clk) begin
    exp_t  n;
    string tg;
    bit    acc, any, mn, mp;
    logic [7:0] bb;
    bit    kk;
    started = 1;
    n  = '0;
    tg = "R4";
    if (rst) begin
      e1 = '0; e2 = '0; t1 = "R4"; t2 = "R4";
      m_al = 0; m_known = 0; m_pos = 0; m_prev_bad = 0;
    end else begin
      acc  = rx_code_vld && (rx_aligned || m_al);
      m_al = m_al || rx_aligned;
      n.al = m_al;
      if (acc) begin
        any = 0; mn = 0; mp = 0; bb = '0; kk = 0;
        for (int i = 0; i < 1024; i++)
          if (tbl_ok[i] && tbl_code[i] == rx_code) begin
            any = 1; bb = 8'(i >> 1); kk = i[9];
            if (i[0]) mp = 1; else mn = 1;
          end
        n.vld = 1;
        if (!any) begin
          n.ce = 1;
          m_prev_bad = 1;
        end else begin
          n.d = bb; n.k = kk;
          if (!m_known && (mn ^ mp)) tg = "R6";
          if (m_prev_bad) tg = "R9";
          if (m_known) begin
            n.de  = m_pos ? !mp : !mn;
            m_pos = tb_rdnext(rx_code, n.de ? !m_pos : m_pos);
          end else if (mn ^ mp) begin
            m_known = 1;
            m_pos   = tb_rdnext(rx_code, mp);
          end
          m_prev_bad = n.de;
        end
        n.ea = n.ce | n.de;
      end
      e2 = e1; t2 = t1;
      e1 = n;  t1 = tg;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (!e2.vld) begin
        chk(dec_vld == 1'b0, e2.al ? "R8" : "R7", int'(dec_vld), 0);
        chk({dec_byte, dec_ctrl, dec_disp_err, dec_code_err, dec_err} == '0, "R10",
            int'({dec_byte, dec_ctrl, dec_disp_err, dec_code_err, dec_err}), 0);
      end else begin
        chk(dec_vld == 1'b1, "R8", int'(dec_vld), 1);
        chk(dec_byte == e2.d, e2.k ? "R2" : (e2.ce ? "R3" : "R1"), int'(dec_byte), int'(e2.d));
        chk(dec_ctrl == e2.k, "R2", int'(dec_ctrl), int'(e2.k));
        chk(dec_code_err == e2.ce, "R3", int'(dec_code_err), int'(e2.ce));
        chk(dec_disp_err == e2.de, t2, int'(dec_disp_err), int'(e2.de));
        chk(dec_err == e2.ea, "R5", int'(dec_err), int'(e2.ea));
      end
    end
  end

  // ---------------- stimulus ----------------
  bit tx_rp;

  task automatic drive(input logic [9:0] c, input bit v, input bit a);
    @(negedge clk);
    rx_code = c; rx_code_vld = v; rx_aligned = a;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit k);
    logic [9:0] c = tb_enc(b, k, tx_rp);
    drive(c, 1, 0);
    tx_rp = tb_rdnext(c, tx_rp);
  endtask

  function automatic logic [7:0] kbyte(input int i);
    logic [7:0] t [4] = '{8'hF7, 8'hFB, 8'hFD, 8'hFE};
    return (i < 8) ? {3'(i), 5'd28} : t[i-8];
  endfunction

  initial begin
    rst = 1; rx_code = '0; rx_code_vld = 0; rx_aligned = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R7: valid words before alignment are dropped
    for (int i = 0; i < 4; i++) drive(tb_enc(8'hBC, 1, i[0]), 1, 0);
    drive('0, 0, 1);
    drive('0, 0, 0);
    // R6: balanced first word leaves polarity unknown; K28.5 (+) then sets it
    tx_rp = 1;
    send_byte(8'hB5, 0);
    send_byte(8'hBC, 1);
    // R1: every data value, with idle gaps
    for (int b = 0; b < 256; b++) begin
      send_byte(8'(b), 0);
      if (b % 50 == 49) drive('0, 0, 0);
    end
    // R2: all control characters
    for (int i = 0; i < 12; i++) send_byte(kbyte(i), 1);
    // R4: word encoded under the wrong polarity
    begin
      logic [9:0] c = tb_enc(8'h00, 0, !tx_rp);
      drive(c, 1, 0);
      tx_rp = tb_rdnext(c, !tx_rp);
    end
    send_byte(8'h4A, 0);
    send_byte(8'h03, 0);
    // R3, R9: invalid patterns hold the running disparity
    drive(10'h000, 1, 0);
    drive(10'h3FF, 1, 0);
    drive(10'b0011111111, 1, 0);
    send_byte(8'h00, 0);
    send_byte(8'h1C, 1);
    // raw random patterns
    for (int i = 0; i < 500; i++) drive(10'($urandom), ($urandom % 4) != 0, 0);
    // mid-stream reset, alignment arriving with the first word
    @(negedge clk); rst = 1;
    @(negedge clk);
    @(negedge clk); rst = 0;
    drive(tb_enc(8'hBC, 1, 0), 1, 0);
    tx_rp = 0;
    begin
      logic [9:0] c = tb_enc(8'hBC, 1, tx_rp);
      drive(c, 1, 1);
      tx_rp = tb_rdnext(c, tx_rp);
    end
    // mixed random stream
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 100);
      if (r < 10) drive('0, 0, 0);
      else if (r < 14) drive(10'($urandom), 1, 0);
      else if (r < 19) begin
        logic [9:0] c = tb_enc(8'($urandom), 0, !tx_rp);
        drive(c, 1, 0);
        tx_rp = tb_rdnext(c, !tx_rp);
      end else if (r < 31) send_byte(kbyte(int'($urandom % 12)), 1);
      else send_byte(8'($urandom), 0);
    end
    repeat (4) drive('0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule